// File: doc/BRIEF.md
# Clock-Gated Simple Dual-Port RAM

This block models a synchronous embedded memory with one write port and one read port on a shared clock. Each port has two controls. The first is a port clock enable, which decides whether the memory core on that side does any work in a cycle. The second is an access enable, which decides whether the cycle actually stores or returns data. A transform stage sits in front of each port. It remaps the access enables onto the port clock enables so that the core on that side stays idle in cycles where nothing is written or read.

A mode input chooses how the two controls are merged:
- **Pass-through:** the user clock enable is used unchanged.
- **Convert:** on a port that has no user clock enable, the access enable becomes the clock enable and the access enable is tied high. A port that does have a user clock enable is left as it is.
- **Combine:** the clock enable is the AND of the user clock enable and the access enable.

A separate single-port input holds the read port's core clock enable low. Stored data and read results are the same in every mode; only the amount of core activity changes. One activity counter per port counts the cycles in which that port's core was clocked. This makes the saving visible at the ports.

The ports are plain memory pins with no handshake. Both ports accept a request in every cycle, so there is no back-pressure to manage.

Top module: `gated_sdp_ram`

## Requirements
- R1: A write takes place at a clock edge when the write-side user enable and `wr_en` are both 1. A read takes place at a clock edge when the read-side user enable and `rd_en` are both 1 and `single_port` is 0. The user enable of a port built without a user clock enable counts as 1. A read loads the addressed word into `rd_data`, where it is visible after that edge.
- R2: If a read and a write target the same address at the same edge, `rd_data` returns the word stored before that write.
- R3: In any cycle without a read, `rd_data` keeps its previous value.
- R4: The `mode` encoding is 0 for pass-through, 1 for convert, 2 for combine, and 3 for convert.
- R5: In pass-through mode, a port's core is active in every cycle in which its user enable is 1.
- R6: In convert mode, a port built without a user clock enable is active only when its access enable is 1. A port built with a user clock enable behaves as in pass-through mode.
- R7: In combine mode, a port's core is active only when its user enable and its access enable are both 1.
- R8: While `single_port` is 1, the read core is never active, `rd_act_cnt` does not change, `rd_data` holds its value, and writes still take place.
- R9: Each CNT_W-bit activity counter increases by exactly one in every cycle in which its port's core is active. It does not change in any other cycle, and it wraps at its maximum.
- R10: Synchronous active-high `rst` clears `rd_data` and both counters to zero.
- R11: For the same input sequence, stored data and `rd_data` are identical in all modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Enable transform select (R4 encoding) |
| single_port | input | 1 | Holds the read core clock enable low |
| wr_clk_en | input | 1 | Write-side user clock enable (ignored when A_USER_CE=0) |
| wr_en | input | 1 | Write access enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_clk_en | input | 1 | Read-side user clock enable (ignored when B_USER_CE=0) |
| rd_en | input | 1 | Read access enable |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read result |
| wr_act_cnt | output | CNT_W | Write core activity count |
| rd_act_cnt | output | CNT_W | Read core activity count |

## Verification
Every result appears one clock edge after the inputs that cause it are sampled. This applies to `rd_data`, which is loaded at the edge where the read is taken, and to both counters, which step at that same edge. The bench drives a full set of inputs on a falling edge and updates its reference model at the same time. It then waits for the next falling edge before comparing all three outputs, so exactly one rising edge lies between the stimulus and each comparison. The same-address collision case (R2) is checked at the edge that follows the collision, and the written value is checked one edge after that.

// File: rtl/gsdp_pkg.sv
package gsdp_pkg;

  typedef enum logic [1:0] {
    XF_PASS    = 2'd0,
    XF_CONVERT = 2'd1,
    XF_COMBINE = 2'd2,
    XF_SPARE   = 2'd3
  } xform_mode_e;

  // The spare encoding falls back to the default conversion behaviour.
  function automatic xform_mode_e decode_mode(input logic [1:0] code);
    xform_mode_e m;
    case (code)
      2'd0:    m = XF_PASS;
      2'd2:    m = XF_COMBINE;
      default: m = XF_CONVERT;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/gsdp_enable_xform.sv
module gsdp_enable_xform
  import gsdp_pkg::*;
#(
  parameter bit HAS_USER_CE = 1'b1
) (
  input  xform_mode_e mode,
  input  logic        shut_off,
  input  logic        user_ce,
  input  logic        access_en,
  output logic        core_ce,
  output logic        core_en
);

  logic uce;
  logic conv_ce;
  logic conv_en;

  // A port with no user clock enable behaves as if that enable were tied high.
  assign uce = HAS_USER_CE ? user_ce : 1'b1;

  generate
    if (HAS_USER_CE) begin : g_conv_skip
      assign conv_ce = uce;
      assign conv_en = access_en;
    end else begin : g_conv_move
      assign conv_ce = access_en;
      assign conv_en = 1'b1;
    end
  endgenerate

  always_comb begin
    core_ce = uce;
    core_en = access_en;
    case (mode)
      XF_PASS: begin
        core_ce = uce;
        core_en = access_en;
      end
      XF_COMBINE: begin
        core_ce = uce & access_en;
        core_en = 1'b1;
      end
      default: begin
        core_ce = conv_ce;
        core_en = conv_en;
      end
    endcase
    if (shut_off) begin
      core_ce = 1'b0;
    end
  end

endmodule

// File: rtl/gsdp_core.sv
module gsdp_core #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ce,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_ce && wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Nonblocking update: a read at the write address sees the old word.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_ce && rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/gsdp_act_counter.sv
module gsdp_act_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (tick) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/gated_sdp_ram.sv
module gated_sdp_ram
  import gsdp_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 32,
  parameter bit A_USER_CE = 1'b0,
  parameter bit B_USER_CE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              single_port,
  input  logic              wr_clk_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  wr_act_cnt,
  output logic [CNT_W-1:0]  rd_act_cnt
);

  xform_mode_e sel_mode;
  logic        wr_core_ce;
  logic        wr_core_en;
  logic        rd_core_ce;
  logic        rd_core_en;

  assign sel_mode = decode_mode(mode);

  gsdp_enable_xform #(.HAS_USER_CE(A_USER_CE)) u_wr_xf (
    .mode      (sel_mode),
    .shut_off  (1'b0),
    .user_ce   (wr_clk_en),
    .access_en (wr_en),
    .core_ce   (wr_core_ce),
    .core_en   (wr_core_en)
  );

  gsdp_enable_xform #(.HAS_USER_CE(B_USER_CE)) u_rd_xf (
    .mode      (sel_mode),
    .shut_off  (single_port),
    .user_ce   (rd_clk_en),
    .access_en (rd_en),
    .core_ce   (rd_core_ce),
    .core_en   (rd_core_en)
  );

  gsdp_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .wr_ce   (wr_core_ce),
    .wr_en   (wr_core_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_ce   (rd_core_ce),
    .rd_en   (rd_core_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  gsdp_act_counter #(.CNT_W(CNT_W)) u_wr_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (wr_core_ce),
    .count (wr_act_cnt)
  );

  gsdp_act_counter #(.CNT_W(CNT_W)) u_rd_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (rd_core_ce),
    .count (rd_act_cnt)
  );

endmodule

// File: rtl/gsdp_checker.sv
module gsdp_checker #(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 32,
  parameter bit A_USER_CE = 1'b0,
  parameter bit B_USER_CE = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              single_port,
  input logic              wr_en,
  input logic              rd_clk_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  wr_act_cnt,
  input logic [CNT_W-1:0]  rd_act_cnt,
  input logic              wr_core_ce,
  input logic              rd_core_ce
);

  logic no_read;
  assign no_read = !rd_en || (B_USER_CE && !rd_clk_en) || single_port;

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    no_read |=> $stable(rd_data));

  assert_sp_idle_R8: assert property (@(posedge clk) disable iff (rst)
    single_port |-> !rd_core_ce);

  assert_rd_step_R9: assert property (@(posedge clk) disable iff (rst)
    rd_core_ce |=> rd_act_cnt == $past(rd_act_cnt) + CNT_W'(1));

  assert_wr_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_core_ce |=> $stable(wr_act_cnt));

  assert_combine_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && !wr_en) |=> $stable(wr_act_cnt));

  assert_convert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'd1 || mode == 2'd3) && !wr_en && !A_USER_CE) |=> $stable(wr_act_cnt));

endmodule

bind gated_sdp_ram gsdp_checker #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .A_USER_CE(A_USER_CE), .B_USER_CE(B_USER_CE)
) u_gsdp_checker (
  .clk         (clk),
  .rst         (rst),
  .mode        (mode),
  .single_port (single_port),
  .wr_en       (wr_en),
  .rd_clk_en   (rd_clk_en),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .wr_act_cnt  (wr_act_cnt),
  .rd_act_cnt  (rd_act_cnt),
  .wr_core_ce  (wr_core_ce),
  .rd_core_ce  (rd_core_ce)
);

// File: tb/test_gated_sdp_ram.sv
`timescale 1ns/1ps
module test_gated_sdp_ram;

  localparam int  AW = 6;
  localparam int  DW = 16;
  localparam int  CW = 32;
  localparam bit  A_HAS = 1'b0;
  localparam bit  B_HAS = 1'b1;
  localparam int  DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    mode;
  logic          single_port;
  logic          wr_clk_en, wr_en, rd_clk_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] wr_act_cnt, rd_act_cnt;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [DW-1:0] mdl [DEPTH];
  logic [DW-1:0] exp_rd;
  logic [CW-1:0] exp_wc, exp_rc;

  always #10 clk = ~clk;

  gated_sdp_ram #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW),
                  .A_USER_CE(A_HAS), .B_USER_CE(B_HAS)) i_gated_sdp_ram (
    .clk(clk), .rst(rst), .mode(mode), .single_port(single_port),
    .wr_clk_en(wr_clk_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk_en(rd_clk_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_act_cnt(wr_act_cnt), .rd_act_cnt(rd_act_cnt)
  );

  function automatic bit core_act(input logic [1:0] m, input bit has, input bit ce, input bit en);
    bit u;
    u = has ? ce : 1'b1;
    case (m)
      2'd0:    return u;
      2'd2:    return u & en;
      default: return has ? u : en;
    endcase
  endfunction

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Called at a falling edge; applies inputs, updates model, checks one edge later.
  task automatic step(input logic [1:0] m, input bit sp,
                      input bit wce, input bit we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input bit rce, input bit re, input logic [AW-1:0] ra,
                      input string tag_rd, input string tag_cnt);
    bit wop, rop;
    mode = m; single_port = sp;
    wr_clk_en = wce; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_clk_en = rce; rd_en = re; rd_addr = ra;
    wop = (A_HAS ? wce : 1'b1) & we;
    rop = (B_HAS ? rce : 1'b1) & re & !sp;
    if (rop) exp_rd = mdl[ra];
    if (wop) mdl[wa] = wd;
    if (core_act(m, A_HAS, wce, we)) exp_wc = exp_wc + 1;
    if (!sp && core_act(m, B_HAS, rce, re)) exp_rc = exp_rc + 1;
    @(negedge clk);
    check(tag_rd, CW'(rd_data), CW'(exp_rd));
    check({tag_cnt, " wr count"}, wr_act_cnt, exp_wc);
    check({tag_cnt, " rd count"}, rd_act_cnt, exp_rc);
  endtask

  task automatic rand_phase(input int n, input logic [1:0] m, input bit sp,
                            input string tag_rd, input string tag_cnt);
    for (int i = 0; i < n; i++) begin
      step(m, sp, 1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom),
           1'($urandom), 1'($urandom), AW'($urandom), tag_rd, tag_cnt);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20051209));
    rst = 1'b1; mode = 2'd1; single_port = 1'b0;
    wr_clk_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_clk_en = 1'b0; rd_en = 1'b0; rd_addr = '0;
    exp_rd = '0; exp_wc = '0; exp_rc = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 rd_data", CW'(rd_data), '0);
    check("R10 wr count", wr_act_cnt, '0);
    check("R10 rd count", rd_act_cnt, '0);

    // Fill memory in convert mode; read side idle. R9 counting exactness.
    for (int a = 0; a < DEPTH; a++) begin
      step(2'd1, 1'b0, 1'b0, 1'b1, AW'(a), DW'(a * 16'h0101 + 7),
           1'b0, 1'b0, '0, "R3", "R9");
    end
    check("R9 wr count after fill", wr_act_cnt, CW'(DEPTH));

    // R1: directed read back
    step(2'd1, 1'b0, 1'b0, 1'b0, '0, '0, 1'b1, 1'b1, AW'(9), "R1", "R6");
    check("R1 readback", CW'(rd_data), CW'(9 * 16'h0101 + 7));

    // R2: collision returns old word, then the new one
    step(2'd1, 1'b0, 1'b0, 1'b1, AW'(5), 16'hBEEF, 1'b1, 1'b1, AW'(5), "R2", "R6");
    check("R2 old word", CW'(rd_data), CW'(5 * 16'h0101 + 7));
    step(2'd1, 1'b0, 1'b0, 1'b0, '0, '0, 1'b1, 1'b1, AW'(5), "R2", "R6");
    check("R2 new word", CW'(rd_data), 32'hBEEF);

    // R3: read clock enable low holds output
    step(2'd2, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1, AW'(9), "R3", "R7");

    // R5: pass-through, write core active without any write
    step(2'd0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, "R3", "R5");

    rand_phase(300, 2'd0, 1'b0, "R11", "R5");
    rand_phase(300, 2'd1, 1'b0, "R1", "R6");
    rand_phase(300, 2'd2, 1'b0, "R11", "R7");
    rand_phase(200, 2'd3, 1'b0, "R1", "R4");
    rand_phase(200, 2'd1, 1'b1, "R8", "R8");
    rand_phase(100, 2'd2, 1'b1, "R8", "R8");
    rand_phase(100, 2'd0, 1'b0, "R3", "R5");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule